// File: doc/BRIEF.md
# Two-Wire Byte Shifter with Own-Address Match

This block is the byte-level datapath of a two-wire serial bus controller. A single data register serves both directions. On every bit strobe from the external bit-timing logic it takes in the sampled SDA value at the least significant end. Its most significant bit is what the unit drives onto SDA. Because every transmitted bit is also read back, the register always ends a byte holding the byte that actually appeared on the wire. A bit counter tracks eight data slots and one acknowledge slot. After the acknowledge slot a byte-done flag is raised, and it stalls the shifter until software clears it.

The first byte after a START indication is also checked as an address. Its upper seven bits are compared with a programmable own address. They are also tested against the all-zero general-call value, which counts only when an enable bit in the address register is set. The match result and the received read/write bit are brought out on their own pins. An address byte that neither matches nor belongs to a transmitting unit leaves the block idle until the next START.

Software accesses the data and address registers through a simple register port. The data register accepts writes only while the byte-done flag is set.

Top module: `tw_byte_shifter`

## Requirements
- R1: After reset the data register reads 0xFF, the address register reads 0xFE (own address all ones, general-call enable bit 0 cleared), byte_done is 0 and sda_out is 1.
- R2: A CPU write to the data register is stored only while byte_done is 1. A write while byte_done is 0 leaves the readback unchanged.
- R3: The address register is written by the CPU at any time and reads back the written value. Bits 7..1 hold the own address and bit 0 holds the general-call enable.
- R4: During the eight data slots with tx_mode=1, sda_out carries the data register MSB first. With tx_mode=0, sda_out stays released (1).
- R5: On each data-slot strobe the sampled sda_in enters at bit 0 and the register shifts toward bit 7. After eight data slots the data register equals the eight sampled bits, first sampled in bit 7.
- R6: The strobe in the ninth (acknowledge) slot sets byte_done. While byte_done is 1, bit strobes change neither the data register nor the flag.
- R7: cpu_flag_clr=1 while byte_done is 1 clears the flag on the next edge, and the following strobes shift the next byte.
- R8: The first byte after bus_start is an address byte. addr_hit is set when its bits 7..1 equal the own address, or when they are all zero and general-call enable is 1. gcall_hit is set only by the second case. byte_done is raised when addr_hit is set or tx_mode is 1. Otherwise the unit ignores strobes until the next bus_start.
- R9: rw_bit reports bit 0 of the last address byte from its acknowledge slot until the next bus_start.
- R10: In the acknowledge slot, sda_out is 1 with tx_mode=1. With tx_mode=0 it is 0 for a data byte or a matching address byte, and 1 for a non-matching address. The sda_in sampled in that slot appears on ack_bit and never enters the data register.
- R11: While arb_lost is 1, sda_out is 1 and shifting in continues, so the data register still ends the byte holding the bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_data_we | input | 1 | Write strobe for the data register |
| cpu_addr_we | input | 1 | Write strobe for the address register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_flag_clr | input | 1 | Write-one-to-clear for byte_done |
| cpu_data_rd | output | 8 | Data register readback |
| cpu_addr_rd | output | 8 | Address register readback |
| byte_done | output | 1 | Byte-boundary event flag |
| bus_start | input | 1 | START condition seen (one-cycle pulse) |
| bit_stb | input | 1 | Bit slot strobe from the bit-timing logic |
| sda_in | input | 1 | Sampled SDA value |
| sda_out | output | 1 | SDA drive value (1 = released) |
| tx_mode | input | 1 | 1 = transmitter, 0 = receiver |
| arb_lost | input | 1 | Arbitration lost, stop driving SDA |
| addr_hit | output | 1 | Last address byte matched |
| gcall_hit | output | 1 | Last address byte was a general call |
| rw_bit | output | 1 | R/W bit of the last address byte |
| ack_bit | output | 1 | SDA value seen in the acknowledge slot |

## Verification
The bench builds the block with its default byte width of eight bits and the reset constants 0xFF/0xFE. At this width the address comparator can be swept over all 256 received address bytes, with the general-call enable both off and on, for own addresses 0x00, 0x2A and 0x7F. The 0x00 own address puts the general-call and own-address cases on the same byte. Directed transfers cover transmit echo, the receive acknowledge drive, the flag stall and arbitration loss partway through a byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  // upper bits of received byte against own address field
  function automatic logic own_match(input logic [BYTE_W-1:0] rx,
                                     input logic [BYTE_W-1:0] areg);
    return rx[BYTE_W-1:1] == areg[BYTE_W-1:1];
  endfunction

  // all-zero address accepted only with enable bit set
  function automatic logic gcall_match(input logic [BYTE_W-1:0] rx,
                                       input logic [BYTE_W-1:0] areg);
    return (rx[BYTE_W-1:1] == '0) && areg[0];
  endfunction
endpackage

// File: rtl/tw_slot_counter.sv
module tw_slot_counter #(
  parameter int SLOTS = 9,
  localparam int CW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  output logic [CW-1:0] slot,
  output logic          ack_slot
);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot <= '0;
    else if (restart) slot <= '0;
    else if (advance) slot <= (slot == LAST) ? '0 : slot + 1'b1;
  end

  assign ack_slot = (slot == LAST);
endmodule

// File: rtl/tw_shift_reg.sv
module tw_shift_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         bit_in,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST;
    else if (shift) q <= {q[W-2:0], bit_in};
    else if (load)  q <= load_val;
  end
endmodule

// File: rtl/tw_addr_cmp.sv
module tw_addr_cmp
  import tw_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] areg,
  output logic              hit,
  output logic              gc_hit
);
  logic own_hit;
  assign own_hit = own_match(rx_byte, areg);
  assign gc_hit  = gcall_match(rx_byte, areg);
  assign hit     = own_hit | gc_hit;
endmodule

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter
  import tw_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DATA_RST = 8'hFF,
  parameter logic [BYTE_W-1:0] ADDR_RST = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_data_we,
  input  logic              cpu_addr_we,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic              cpu_flag_clr,
  output logic [BYTE_W-1:0] cpu_data_rd,
  output logic [BYTE_W-1:0] cpu_addr_rd,
  output logic              byte_done,
  input  logic              bus_start,
  input  logic              bit_stb,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              tx_mode,
  input  logic              arb_lost,
  output logic              addr_hit,
  output logic              gcall_hit,
  output logic              rw_bit,
  output logic              ack_bit
);
  localparam int SLOTS = BYTE_W + 1;
  localparam int CW    = $clog2(SLOTS);

  logic          active, first_byte;
  logic          ack_slot;
  logic [CW-1:0] slot;
  logic          shift_en, data_stb, ack_stb;
  logic          cmp_hit, cmp_gc;
  logic [BYTE_W-1:0] dreg, areg;

  // named internal events
  assign shift_en = active && !byte_done && bit_stb && !bus_start;
  assign data_stb = shift_en && !ack_slot;
  assign ack_stb  = shift_en && ack_slot;

  tw_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(bus_start), .advance(shift_en),
    .slot(slot), .ack_slot(ack_slot)
  );

  tw_shift_reg #(.W(BYTE_W), .RST(DATA_RST)) u_data (
    .clk(clk), .rst_n(rst_n), .shift(data_stb), .bit_in(sda_in),
    .load(cpu_data_we && byte_done), .load_val(cpu_wdata), .q(dreg)
  );

  tw_addr_cmp u_cmp (
    .rx_byte(dreg), .areg(areg), .hit(cmp_hit), .gc_hit(cmp_gc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           areg <= ADDR_RST;
    else if (cpu_addr_we) areg <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      first_byte <= 1'b0;
      byte_done  <= 1'b0;
      addr_hit   <= 1'b0;
      gcall_hit  <= 1'b0;
      rw_bit     <= 1'b0;
      ack_bit    <= 1'b1;
    end else if (bus_start) begin
      active     <= 1'b1;
      first_byte <= 1'b1;
      byte_done  <= 1'b0;
      addr_hit   <= 1'b0;
      gcall_hit  <= 1'b0;
    end else if (ack_stb) begin
      ack_bit    <= sda_in;
      first_byte <= 1'b0;
      if (first_byte) begin
        addr_hit  <= cmp_hit;
        gcall_hit <= cmp_gc;
        rw_bit    <= dreg[0];
        byte_done <= cmp_hit || tx_mode;
        active    <= cmp_hit || tx_mode;
      end else begin
        byte_done <= 1'b1;
      end
    end else if (cpu_flag_clr && byte_done) begin
      byte_done <= 1'b0;
    end
  end

  always_comb begin
    if (!active || byte_done || arb_lost) sda_out = 1'b1;
    else if (ack_slot)                    sda_out = tx_mode | (first_byte & ~cmp_hit);
    else                                  sda_out = tx_mode ? dreg[BYTE_W-1] : 1'b1;
  end

  assign cpu_data_rd = dreg;
  assign cpu_addr_rd = areg;
endmodule

// File: rtl/tw_byte_shifter_chk.sv
module tw_byte_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_data_we,
  input logic       cpu_flag_clr,
  input logic [7:0] cpu_data_rd,
  input logic       byte_done,
  input logic       bus_start,
  input logic       bit_stb,
  input logic       sda_out,
  input logic       tx_mode,
  input logic       arb_lost,
  input logic       addr_hit,
  input logic       gcall_hit,
  input logic       ack_slot
);
  // R2: without the flag, data only moves by a strobe
  p_write_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_done && !bit_stb) |=> $stable(cpu_data_rd));

  // R6: strobes stall while the flag is up
  p_stall_on_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && bit_stb && !cpu_data_we && !bus_start) |=> ($stable(cpu_data_rd) && byte_done));

  // R7: clear drops the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cpu_flag_clr && !bus_start) |=> !byte_done);

  // R8: general call is a kind of hit
  p_gc_is_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_hit |-> addr_hit);

  // R10: transmitter releases the acknowledge slot
  p_ack_release_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot && tx_mode) |-> sda_out);

  // R11: no drive after arbitration loss
  p_release_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> sda_out);
endmodule

bind tw_byte_shifter tw_byte_shifter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_data_we(cpu_data_we), .cpu_flag_clr(cpu_flag_clr),
  .cpu_data_rd(cpu_data_rd), .byte_done(byte_done), .bus_start(bus_start),
  .bit_stb(bit_stb), .sda_out(sda_out), .tx_mode(tx_mode), .arb_lost(arb_lost),
  .addr_hit(addr_hit), .gcall_hit(gcall_hit), .ack_slot(ack_slot)
);

// File: tb/test_tw_byte_shifter.sv
module test_tw_byte_shifter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_data_we = 0, cpu_addr_we = 0, cpu_flag_clr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_data_rd, cpu_addr_rd;
  logic byte_done, bus_start = 0, bit_stb = 0, sda_in = 1, sda_out;
  logic tx_mode = 0, arb_lost = 0, addr_hit, gcall_hit, rw_bit, ack_bit;

  int checks = 0, failures = 0;
  logic [8:0] seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_byte_shifter i_tw_byte_shifter (.*);

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1;
    @(negedge clk) bus_start = 0;
  endtask

  task automatic cpu_data(input logic [7:0] v);
    @(negedge clk) begin cpu_data_we = 1; cpu_wdata = v; end
    @(negedge clk) cpu_data_we = 0;
  endtask

  task automatic cpu_addr(input logic [7:0] v);
    @(negedge clk) begin cpu_addr_we = 1; cpu_wdata = v; end
    @(negedge clk) cpu_addr_we = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk) cpu_flag_clr = 1;
    @(negedge clk) cpu_flag_clr = 0;
  endtask

  // one bit slot: record the drive value before the strobe edge
  task automatic slot(input logic b, output logic drv);
    @(negedge clk) begin sda_in = b; bit_stb = 1; end
    #1 drv = sda_out;
    @(negedge clk) bit_stb = 0;
  endtask

  // eight data bits MSB first, then the acknowledge slot value
  task automatic xfer(input logic [7:0] bus, input logic ack, output logic [8:0] drv);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      slot(bus[i], d);
      drv[i+1] = d;
    end
    slot(ack, d);
    drv[0] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] owns [3];
    owns[0] = 8'h00; owns[1] = 8'h2A; owns[2] = 8'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(cpu_data_rd == 8'hFF, "R1 data reset", cpu_data_rd, 8'hFF);
    check(cpu_addr_rd == 8'hFE, "R1 addr reset", cpu_addr_rd, 8'hFE);
    check(byte_done == 0 && sda_out == 1, "R1 flag/sda reset", {byte_done, sda_out}, 1);
    // R2: write ignored without flag
    cpu_data(8'h12);
    check(cpu_data_rd == 8'hFF, "R2 write ignored", cpu_data_rd, 8'hFF);
    // R3
    cpu_addr(8'h55);
    check(cpu_addr_rd == 8'h55, "R3 addr readback", cpu_addr_rd, 8'h55);

    // R8 sweep, receiver mode
    tx_mode = 0;
    for (int o = 0; o < 3; o++) begin
      for (int g = 0; g < 2; g++) begin
        for (int rx = 0; rx < 256; rx++) begin
          logic [7:0] rb;
          logic exp_gc, exp_hit;
          rb = 8'(rx);
          exp_gc  = (rb[7:1] == 7'd0) && (g == 1);
          exp_hit = (rb[7:1] == owns[o][6:0]) || exp_gc;
          cpu_addr({owns[o][6:0], 1'(g)});
          pulse_start();
          xfer(rb, 1'b1, seen);
          @(negedge clk);
          check(byte_done == exp_hit, "R8 flag on match", byte_done, exp_hit);
          check(addr_hit == exp_hit && gcall_hit == exp_gc, "R8 hit outputs",
                {addr_hit, gcall_hit}, {exp_hit, exp_gc});
          check(rw_bit == rb[0], "R9 rw bit", rw_bit, rb[0]);
          check(seen[0] == !exp_hit, "R10 address ack drive", seen[0], !exp_hit);
          check(seen[8:1] == 8'hFF, "R4 rx releases data slots", seen[8:1], 8'hFF);
          check(cpu_data_rd == rb, "R5 address byte captured", cpu_data_rd, rb);
        end
      end
    end

    // R8: no match leaves the unit idle
    cpu_addr(8'h54);
    pulse_start();
    xfer(8'h20, 1'b1, seen);
    xfer(8'h0F, 1'b0, seen);
    @(negedge clk);
    check(cpu_data_rd == 8'h20 && byte_done == 0, "R8 idle after miss",
          {byte_done, cpu_data_rd}, 8'h20);

    // transmit: address byte always flags with tx_mode=1
    tx_mode = 1;
    pulse_start();
    xfer(8'h10, 1'b0, seen);
    @(negedge clk);
    check(byte_done == 1 && addr_hit == 0, "R8 tx address flags", {byte_done, addr_hit}, 2);
    cpu_data(8'hA5);
    check(cpu_data_rd == 8'hA5, "R2 write accepted with flag", cpu_data_rd, 8'hA5);
    clear_flag();
    check(byte_done == 0, "R7 flag cleared", byte_done, 0);
    // bus echoes sda_out bit by bit
    begin
      logic d;
      for (int i = 8; i >= 1; i--) begin
        @(negedge clk) #1;
        slot(sda_out, d);
        seen[i] = d;
      end
      slot(1'b0, d);
      seen[0] = d;
    end
    @(negedge clk);
    check(seen == {8'hA5, 1'b1}, "R4 tx MSB first, R10 ack released", seen, {8'hA5, 1'b1});
    check(cpu_data_rd == 8'hA5, "R5 echo byte", cpu_data_rd, 8'hA5);
    check(ack_bit == 0 && byte_done == 1, "R10 ack bit, R6 flag", {ack_bit, byte_done}, 1);
    // R6: strobes ignored while flagged
    begin
      logic d;
      for (int i = 0; i < 4; i++) slot(1'b0, d);
    end
    @(negedge clk);
    check(cpu_data_rd == 8'hA5 && byte_done == 1, "R6 stall", cpu_data_rd, 8'hA5);

    // R11: arbitration lost on third bit of 0xF0, bus carries 0xC3
    cpu_data(8'hF0);
    clear_flag();
    xfer_lost: begin
      logic d;
      logic [7:0] bus;
      logic ok;
      bus = 8'hC3;
      ok = 1;
      for (int i = 7; i >= 0; i--) begin
        if (i == 5) arb_lost = 1;
        slot(bus[i], d);
        if (i <= 5 && d != 1'b1) ok = 0;
      end
      slot(1'b0, d);
      if (d != 1'b1) ok = 0;
      check(ok, "R11 released after loss", ok, 1);
    end
    @(negedge clk);
    check(cpu_data_rd == 8'hC3, "R11 byte intact", cpu_data_rd, 8'hC3);
    arb_lost = 0;

    // receiver data byte
    tx_mode = 0;
    clear_flag();
    xfer(8'h3C, 1'b1, seen);
    @(negedge clk);
    check(seen == 9'h1FE, "R4 rx released, R10 data ack low", seen, 9'h1FE);
    check(cpu_data_rd == 8'h3C, "R5 rx byte", cpu_data_rd, 8'h3C);
    check(ack_bit == 1, "R10 ack bit not in data", ack_bit, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule